// File: doc/BRIEF.md
# Segmented Effective Address Generator

This unit turns an operand reference into a memory location. From the current pointer-register values (BX, BP, SI, DI), an addressing-mode code and an optional displacement, it forms a 16-bit effective offset. It then picks one of four segment registers and forms a 20-bit physical address. To do this it shifts the segment value left by four bits and adds the offset.

The segment is picked by a fixed default rule: stack for any BP-based reference, data otherwise. An explicit override can replace that choice. String operations that address through DI always use the extra segment.

A request strobe samples all inputs. One clock later the offset, the segment identifier and the physical address appear on registered outputs, together with a one-cycle valid flag. Between requests the outputs keep their last values.

Top module: `agu_ea_gen`

## Requirements
- R1: The physical address is (segment value × 16 + effective offset) modulo 2^20. Segment 1055h with offset 5555h gives 15AA5h, and segment FFFFh with offset 0020h gives 00010h.
- R2: The mode code selects how the offset is formed:
  - 000 is direct and uses the full 16-bit displacement.
  - 001 is register-indirect and uses the register named by the pointer select (00 BX, 01 BP, 10 SI, 11 DI).
  - 010 is base plus displacement.
  - 011 is index plus displacement.
  - 100 is base plus index plus displacement.
  - Codes 101 to 111 behave as direct.
  - The base select picks BX (0) or BP (1). The index select picks SI (0) or DI (1).
- R3: The displacement kind sets the displacement term used by modes 010 to 100:
  - 00 adds zero.
  - 01 sign-extends the low 8 bits of the displacement to 16 bits.
  - 10 and 11 add the full 16 bits.
  - The direct mode ignores the kind.
- R4: The offset sum wraps modulo 2^16 before the segment is added.
- R5: With no override and no string rule in force, the segment is stack (code 10) when BP takes part in the reference, and data (code 11) otherwise.
- R6: When the override enable is high, the segment code comes from the override select (00 extra, 01 code, 10 stack, 11 data) in place of the default.
- R7: When the string flag is high and DI takes part in the reference, the segment is extra (code 00), whatever the override inputs say. With SI, the string flag changes nothing.
- R8: A request at a clock edge updates the outputs at that edge and raises valid for exactly the following cycle. Without a request, valid is low and the outputs hold.
- R9: During reset, valid, offset, segment code and physical address are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 1 | Request strobe; samples all inputs |
| mode_i | input | 3 | Addressing-mode code |
| ptr_sel_i | input | 2 | Register for register-indirect mode |
| base_sel_i | input | 1 | Base register select (0 BX, 1 BP) |
| index_sel_i | input | 1 | Index register select (0 SI, 1 DI) |
| disp_kind_i | input | 2 | Displacement kind |
| disp_i | input | 16 | Displacement / direct offset |
| bx_i | input | 16 | BX value |
| bp_i | input | 16 | BP value |
| si_i | input | 16 | SI value |
| di_i | input | 16 | DI value |
| es_i | input | 16 | Extra segment value |
| cs_i | input | 16 | Code segment value |
| ss_i | input | 16 | Stack segment value |
| ds_i | input | 16 | Data segment value |
| ovr_en_i | input | 1 | Segment override enable |
| ovr_sel_i | input | 2 | Override segment code |
| str_op_i | input | 1 | String-operation flag |
| vld_o | output | 1 | Result valid, one cycle |
| ea_o | output | 16 | Effective offset |
| seg_id_o | output | 2 | Segment code used |
| phys_o | output | 20 | Physical address |

## Verification
The hardest situation to reach is the conflict between segment rules. In that case the string flag, a DI reference and an active override all arrive together, sometimes with BP as the base as well, so three rules compete for the segment. Random stimulus reaches it by sweeping every mode code, register select, override code and string flag on each request. Directed requests pin down the outcome, and further directed requests force carries out of both the 16-bit offset sum and the 20-bit address sum by using register and segment values near all-ones. Idle cycles are mixed in to show that the outputs hold between requests.

// File: rtl/agu_pkg.sv
// Package: shared codes for the effective address generator.
// Assumes a 2-bit segment code and a 3-bit mode code.
package agu_pkg;

    typedef enum logic [1:0] {
        SG_EXTRA = 2'd0,
        SG_CODE  = 2'd1,
        SG_STACK = 2'd2,
        SG_DATA  = 2'd3
    } seg_id_e;

    localparam logic [2:0] AM_DIRECT     = 3'd0;
    localparam logic [2:0] AM_REG_IND    = 3'd1;
    localparam logic [2:0] AM_BASE_REL   = 3'd2;
    localparam logic [2:0] AM_INDEX_REL  = 3'd3;
    localparam logic [2:0] AM_BASE_INDEX = 3'd4;

    localparam logic [1:0] DK_NONE = 2'd0;
    localparam logic [1:0] DK_BYTE = 2'd1;

    localparam logic [1:0] PTR_BX = 2'd0;
    localparam logic [1:0] PTR_BP = 2'd1;
    localparam logic [1:0] PTR_SI = 2'd2;
    localparam logic [1:0] PTR_DI = 2'd3;

endpackage

// File: rtl/agu_disp_ext.sv
// Displacement extender: produces the displacement term for the offset adder.
// Assumes the short form sits in the low SHORT_W bits of the displacement.
module agu_disp_ext #(
    parameter int unsigned OFS_W   = 16,
    parameter int unsigned SHORT_W = 8
) (
    input  logic [1:0]       kind_i,
    input  logic [OFS_W-1:0] disp_i,
    output logic [OFS_W-1:0] term_o
);
    import agu_pkg::*;

    localparam int unsigned EXT_W = OFS_W - SHORT_W;

    logic [OFS_W-1:0] short_ext;

    // Sign-extend the short displacement to the full offset width.
    always_comb begin
        short_ext = {{EXT_W{disp_i[SHORT_W-1]}}, disp_i[SHORT_W-1:0]};
    end

    // Select none, short or full displacement.
    always_comb begin
        unique case (kind_i)
            DK_NONE: term_o = '0;
            DK_BYTE: term_o = short_ext;
            default: term_o = disp_i;
        endcase
    end

endmodule

// File: rtl/agu_offset.sv
// Offset former: chooses up to three addends per mode and sums them modulo
// 2^OFS_W. Also reports whether BP or DI takes part, for segment selection.
// Assumes reserved mode codes behave as direct.
module agu_offset #(
    parameter int unsigned OFS_W = 16
) (
    input  logic [2:0]       mode_i,
    input  logic [1:0]       ptr_sel_i,
    input  logic             base_sel_i,
    input  logic             index_sel_i,
    input  logic [OFS_W-1:0] disp_raw_i,
    input  logic [OFS_W-1:0] disp_term_i,
    input  logic [OFS_W-1:0] bx_i,
    input  logic [OFS_W-1:0] bp_i,
    input  logic [OFS_W-1:0] si_i,
    input  logic [OFS_W-1:0] di_i,
    output logic [OFS_W-1:0] ofs_o,
    output logic             bp_used_o,
    output logic             di_used_o
);
    import agu_pkg::*;

    logic [OFS_W-1:0] base_val;
    logic [OFS_W-1:0] index_val;
    logic [OFS_W-1:0] ptr_val;
    logic [OFS_W-1:0] add_a;
    logic [OFS_W-1:0] add_b;
    logic [OFS_W-1:0] add_c;

    // Resolve the base, index and single-pointer register values.
    always_comb begin
        base_val  = base_sel_i  ? bp_i : bx_i;
        index_val = index_sel_i ? di_i : si_i;
        unique case (ptr_sel_i)
            PTR_BX:  ptr_val = bx_i;
            PTR_BP:  ptr_val = bp_i;
            PTR_SI:  ptr_val = si_i;
            default: ptr_val = di_i;
        endcase
    end

    // Route addends per mode; unused addends are zero.
    always_comb begin
        add_a = '0;
        add_b = '0;
        add_c = '0;
        unique case (mode_i)
            AM_REG_IND:    add_a = ptr_val;
            AM_BASE_REL: begin
                add_a = base_val;
                add_c = disp_term_i;
            end
            AM_INDEX_REL: begin
                add_b = index_val;
                add_c = disp_term_i;
            end
            AM_BASE_INDEX: begin
                add_a = base_val;
                add_b = index_val;
                add_c = disp_term_i;
            end
            default:       add_a = disp_raw_i;
        endcase
    end

    // Three-input sum truncated to the offset width.
    always_comb begin
        ofs_o = add_a + add_b + add_c;
    end

    // Report which pointer registers take part in the reference.
    always_comb begin
        bp_used_o = 1'b0;
        di_used_o = 1'b0;
        unique case (mode_i)
            AM_REG_IND: begin
                bp_used_o = (ptr_sel_i == PTR_BP);
                di_used_o = (ptr_sel_i == PTR_DI);
            end
            AM_BASE_REL:   bp_used_o = base_sel_i;
            AM_INDEX_REL:  di_used_o = index_sel_i;
            AM_BASE_INDEX: begin
                bp_used_o = base_sel_i;
                di_used_o = index_sel_i;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/agu_segsel.sv
// Segment selector: string-with-DI forces the extra segment, otherwise an
// override wins, otherwise BP implies stack and everything else data.
// Assumes the segment bank is indexed by the segment code.
module agu_segsel #(
    parameter int unsigned SEG_W = 16,
    parameter int unsigned N_SEG = 4
) (
    input  logic                       bp_used_i,
    input  logic                       di_used_i,
    input  logic                       str_op_i,
    input  logic                       ovr_en_i,
    input  logic [1:0]                 ovr_sel_i,
    input  logic [N_SEG-1:0][SEG_W-1:0] seg_bank_i,
    output agu_pkg::seg_id_e           seg_id_o,
    output logic [SEG_W-1:0]           seg_val_o
);
    import agu_pkg::*;

    // Priority: string/DI, then override, then default by base register.
    always_comb begin
        if (str_op_i && di_used_i) begin
            seg_id_o = SG_EXTRA;
        end else if (ovr_en_i) begin
            seg_id_o = seg_id_e'(ovr_sel_i);
        end else if (bp_used_i) begin
            seg_id_o = SG_STACK;
        end else begin
            seg_id_o = SG_DATA;
        end
    end

    // Fetch the chosen segment value from the bank.
    always_comb begin
        seg_val_o = seg_bank_i[seg_id_o];
    end

endmodule

// File: rtl/agu_phys.sv
// Physical address adder: segment shifted left by SHIFT plus zero-extended
// offset, truncated to PA_W bits.
module agu_phys #(
    parameter int unsigned SEG_W = 16,
    parameter int unsigned OFS_W = 16,
    parameter int unsigned SHIFT = 4
) (
    input  logic [SEG_W-1:0]       seg_i,
    input  logic [OFS_W-1:0]       ofs_i,
    output logic [SEG_W+SHIFT-1:0] pa_o
);
    localparam int unsigned PA_W = SEG_W + SHIFT;

    logic [PA_W-1:0] seg_sh;
    logic [PA_W-1:0] ofs_ext;

    // Align operands to the physical width.
    always_comb begin
        seg_sh  = {seg_i, {SHIFT{1'b0}}};
        ofs_ext = PA_W'(ofs_i);
    end

    // Sum modulo 2^PA_W.
    always_comb begin
        pa_o = seg_sh + ofs_ext;
    end

endmodule

// File: rtl/agu_ea_gen.sv
// Segmented effective address generator top. Combines offset forming,
// segment selection and the shift-and-add, then registers the result on a
// request strobe with a one-cycle valid. Synchronous active-low reset.
module agu_ea_gen #(
    parameter int unsigned OFS_W   = 16,
    parameter int unsigned SHIFT   = 4,
    parameter int unsigned SHORT_W = 8,
    localparam int unsigned PA_W   = OFS_W + SHIFT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_i,
    input  logic [2:0]       mode_i,
    input  logic [1:0]       ptr_sel_i,
    input  logic             base_sel_i,
    input  logic             index_sel_i,
    input  logic [1:0]       disp_kind_i,
    input  logic [OFS_W-1:0] disp_i,
    input  logic [OFS_W-1:0] bx_i,
    input  logic [OFS_W-1:0] bp_i,
    input  logic [OFS_W-1:0] si_i,
    input  logic [OFS_W-1:0] di_i,
    input  logic [OFS_W-1:0] es_i,
    input  logic [OFS_W-1:0] cs_i,
    input  logic [OFS_W-1:0] ss_i,
    input  logic [OFS_W-1:0] ds_i,
    input  logic             ovr_en_i,
    input  logic [1:0]       ovr_sel_i,
    input  logic             str_op_i,
    output logic             vld_o,
    output logic [OFS_W-1:0] ea_o,
    output logic [1:0]       seg_id_o,
    output logic [PA_W-1:0]  phys_o
);
    import agu_pkg::*;

    localparam int unsigned N_SEG = 4;

    logic [OFS_W-1:0]             disp_term;
    logic [OFS_W-1:0]             ofs_c;
    logic                         bp_used;
    logic                         di_used;
    seg_id_e                      seg_id_c;
    logic [OFS_W-1:0]             seg_val_c;
    logic [PA_W-1:0]              pa_c;
    logic [N_SEG-1:0][OFS_W-1:0]  seg_bank;
    logic [OFS_W-1:0]             seg_val_q;

    // Pack the segment registers in code order.
    always_comb begin
        seg_bank = {ds_i, ss_i, cs_i, es_i};
    end

    agu_disp_ext #(.OFS_W(OFS_W), .SHORT_W(SHORT_W)) u_disp (
        .kind_i (disp_kind_i),
        .disp_i (disp_i),
        .term_o (disp_term)
    );

    agu_offset #(.OFS_W(OFS_W)) u_ofs (
        .mode_i      (mode_i),
        .ptr_sel_i   (ptr_sel_i),
        .base_sel_i  (base_sel_i),
        .index_sel_i (index_sel_i),
        .disp_raw_i  (disp_i),
        .disp_term_i (disp_term),
        .bx_i        (bx_i),
        .bp_i        (bp_i),
        .si_i        (si_i),
        .di_i        (di_i),
        .ofs_o       (ofs_c),
        .bp_used_o   (bp_used),
        .di_used_o   (di_used)
    );

    agu_segsel #(.SEG_W(OFS_W), .N_SEG(N_SEG)) u_seg (
        .bp_used_i  (bp_used),
        .di_used_i  (di_used),
        .str_op_i   (str_op_i),
        .ovr_en_i   (ovr_en_i),
        .ovr_sel_i  (ovr_sel_i),
        .seg_bank_i (seg_bank),
        .seg_id_o   (seg_id_c),
        .seg_val_o  (seg_val_c)
    );

    agu_phys #(.SEG_W(OFS_W), .OFS_W(OFS_W), .SHIFT(SHIFT)) u_pa (
        .seg_i (seg_val_c),
        .ofs_i (ofs_c),
        .pa_o  (pa_c)
    );

    // Valid strobe: high for the cycle after each request.
    always_ff @(posedge clk) begin
        if (!rst_n) vld_o <= 1'b0;
        else        vld_o <= req_i;
    end

    // Result registers: load on request, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ea_o      <= '0;
            seg_id_o  <= '0;
            phys_o    <= '0;
            seg_val_q <= '0;
        end else if (req_i) begin
            ea_o      <= ofs_c;
            seg_id_o  <= seg_id_c;
            phys_o    <= pa_c;
            seg_val_q <= seg_val_c;
        end
    end

    AST_VLD_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_i |=> vld_o); // R8
    AST_VLD_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
        !req_i |=> !vld_o); // R8
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !req_i |=> ($stable(phys_o) && $stable(ea_o) && $stable(seg_id_o))); // R8
    AST_PHYS_SUM: assert property (@(posedge clk) disable iff (!rst_n)
        vld_o |-> (phys_o == (PA_W'({seg_val_q, {SHIFT{1'b0}}}) + PA_W'(ea_o)))); // R1
    AST_STR_DI_EXTRA: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && str_op_i && di_used) |=> (seg_id_o == 2'(SG_EXTRA))); // R7
    AST_BP_STACK: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && !ovr_en_i && !(str_op_i && di_used) && bp_used)
        |=> (seg_id_o == 2'(SG_STACK))); // R5
    AST_OVR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && ovr_en_i && !(str_op_i && di_used)) |=> (seg_id_o == $past(ovr_sel_i))); // R6

endmodule

// File: tb/agu_ea_gen_bench.sv
module agu_ea_gen_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic [2:0]  mode = '0;
    logic [1:0]  ptr_sel = '0;
    logic        base_sel = 1'b0;
    logic        index_sel = 1'b0;
    logic [1:0]  disp_kind = '0;
    logic [15:0] disp = '0, bx = '0, bp = '0, si = '0, di = '0;
    logic [15:0] es = '0, cs = '0, ss = '0, ds = '0;
    logic        ovr_en = 1'b0;
    logic [1:0]  ovr_sel = '0;
    logic        str_op = 1'b0;
    logic        vld;
    logic [15:0] ea;
    logic [1:0]  seg_id;
    logic [19:0] phys;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    int last_ea = 0, last_sid = 0, last_pa = 0;

    always #2 clk = ~clk;

    agu_ea_gen u_agu_ea_gen (
        .clk(clk), .rst_n(rst_n), .req_i(req), .mode_i(mode),
        .ptr_sel_i(ptr_sel), .base_sel_i(base_sel), .index_sel_i(index_sel),
        .disp_kind_i(disp_kind), .disp_i(disp), .bx_i(bx), .bp_i(bp),
        .si_i(si), .di_i(di), .es_i(es), .cs_i(cs), .ss_i(ss), .ds_i(ds),
        .ovr_en_i(ovr_en), .ovr_sel_i(ovr_sel), .str_op_i(str_op),
        .vld_o(vld), .ea_o(ea), .seg_id_o(seg_id), .phys_o(phys)
    );

    task automatic check(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Behavioural reference built from the requirements.
    task automatic model(output int e_ea, output int e_sid, output int e_pa,
                         output bit bp_use, output bit di_use);
        int dterm, basev, idxv, ptrv, ofs, segv;
        if (disp_kind == 2'd0)      dterm = 0;
        else if (disp_kind == 2'd1) dterm = (int'(disp[7:0]) >= 128) ? int'(disp[7:0]) - 256 : int'(disp[7:0]);
        else                        dterm = int'(disp);
        basev = base_sel ? int'(bp) : int'(bx);
        idxv  = index_sel ? int'(di) : int'(si);
        case (ptr_sel)
            2'd0: ptrv = int'(bx);
            2'd1: ptrv = int'(bp);
            2'd2: ptrv = int'(si);
            default: ptrv = int'(di);
        endcase
        bp_use = 1'b0;
        di_use = 1'b0;
        case (mode)
            3'd1: begin ofs = ptrv; bp_use = (ptr_sel == 2'd1); di_use = (ptr_sel == 2'd3); end
            3'd2: begin ofs = basev + dterm; bp_use = base_sel; end
            3'd3: begin ofs = idxv + dterm; di_use = index_sel; end
            3'd4: begin ofs = basev + idxv + dterm; bp_use = base_sel; di_use = index_sel; end
            default: ofs = int'(disp);
        endcase
        ofs = ofs & 32'hFFFF;
        if (str_op && di_use) e_sid = 0;
        else if (ovr_en)      e_sid = int'(ovr_sel);
        else if (bp_use)      e_sid = 2;
        else                  e_sid = 3;
        case (e_sid)
            0: segv = int'(es);
            1: segv = int'(cs);
            2: segv = int'(ss);
            default: segv = int'(ds);
        endcase
        e_ea = ofs;
        e_pa = ((segv << 4) + ofs) & 32'hFFFFF;
    endtask

    // One clock step with the current inputs; checks after the edge.
    task automatic step(string seg_tag_in = "");
        int e_ea, e_sid, e_pa;
        bit bpu, diu;
        string stag;
        model(e_ea, e_sid, e_pa, bpu, diu);
        @(posedge clk);
        @(negedge clk);
        if (req) begin
            check("R8 valid after request", int'(vld), 1);
            check("R2 offset", int'(ea), e_ea);
            if (seg_tag_in != "") stag = seg_tag_in;
            else if (str_op && diu) stag = "R7 segment";
            else if (ovr_en) stag = "R6 segment";
            else stag = "R5 segment";
            check(stag, int'(seg_id), e_sid);
            check("R1 physical", int'(phys), e_pa);
            last_ea = e_ea; last_sid = e_sid; last_pa = e_pa;
        end else begin
            check("R8 valid low when idle", int'(vld), 0);
            check("R8 offset held", int'(ea), last_ea);
            check("R8 segment held", int'(seg_id), last_sid);
            check("R8 physical held", int'(phys), last_pa);
        end
    endtask

    task automatic clear_ctl();
        mode = 3'd0; ptr_sel = 2'd0; base_sel = 1'b0; index_sel = 1'b0;
        disp_kind = 2'd0; ovr_en = 1'b0; ovr_sel = 2'd0; str_op = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R9 reset valid", int'(vld), 0);
        check("R9 reset offset", int'(ea), 0);
        check("R9 reset segment", int'(seg_id), 0);
        check("R9 reset physical", int'(phys), 0);
        rst_n = 1'b1;

        // R1: 1055h:5555h -> 15AA5h via direct mode
        clear_ctl(); req = 1'b1; ds = 16'h1055; disp = 16'h5555;
        step();
        check("R1 worked example", int'(phys), 32'h15AA5);
        // R1: 20-bit wrap
        ds = 16'hFFFF; disp = 16'h0020;
        step();
        check("R1 20-bit wrap", int'(phys), 32'h00010);
        // R3: short displacement sign extension
        ds = 16'h2000; mode = 3'd2; bx = 16'h0100; disp = 16'h3480; disp_kind = 2'd1;
        step();
        check("R3 byte sign-extend", int'(ea), 32'h0080);
        disp_kind = 2'd0;
        step();
        check("R3 no displacement", int'(ea), 32'h0100);
        disp_kind = 2'd3;
        step();
        check("R3 full word", int'(ea), 32'h3580);
        // R4: offset wraps
        mode = 3'd4; bx = 16'hFFFF; si = 16'h0002; disp = 16'h0001; disp_kind = 2'd2;
        step();
        check("R4 offset wrap", int'(ea), 32'h0002);
        // R2: reserved mode behaves as direct
        mode = 3'd6; disp = 16'hBEEF;
        step();
        check("R2 reserved mode", int'(ea), 32'hBEEF);
        // R5: BP base defaults to stack
        ss = 16'h3000; mode = 3'd2; base_sel = 1'b1; bp = 16'h0010; disp_kind = 2'd0;
        step();
        check("R5 BP to stack", int'(seg_id), 2);
        // R6: override to code segment
        cs = 16'h4000; ovr_en = 1'b1; ovr_sel = 2'd1;
        step();
        check("R6 override", int'(seg_id), 1);
        // R7: string with DI ignores override
        es = 16'h5000; mode = 3'd1; ptr_sel = 2'd3; di = 16'h0042; str_op = 1'b1;
        step();
        check("R7 string DI extra", int'(seg_id), 0);
        // R7: string with SI follows override
        ptr_sel = 2'd2;
        step();
        check("R7 string SI normal", int'(seg_id), 1);
        // R8: idle cycles hold outputs
        req = 1'b0; disp = 16'h1111; ds = 16'h7777;
        step(); step();

        // Random sweep over every mode and segment combination
        for (int i = 0; i < 4000; i++) begin
            req = ($urandom_range(0, 9) != 0);
            mode = 3'($urandom_range(0, 7));
            ptr_sel = 2'($urandom); base_sel = 1'($urandom); index_sel = 1'($urandom);
            disp_kind = 2'($urandom); disp = 16'($urandom);
            ovr_en = 1'($urandom); ovr_sel = 2'($urandom); str_op = 1'($urandom);
            if ($urandom_range(0, 3) == 0) begin
                bx = 16'hFFFF - 16'($urandom_range(0, 3)); bp = 16'hFFF0; si = 16'hFFFE; di = 16'hFF00;
                ds = 16'hFFFF; ss = 16'hFFF8; es = 16'hFFFE; cs = 16'hF000;
            end else begin
                bx = 16'($urandom); bp = 16'($urandom); si = 16'($urandom); di = 16'($urandom);
                es = 16'($urandom); cs = 16'($urandom); ss = 16'($urandom); ds = 16'($urandom);
            end
            step();
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule